// File: doc/BRIEF.md
# Two-Wire Bus Bit-Bang Control Register

This block lets software drive a two-wire serial bus by hand. A two-bit output latch holds the wanted level of the clock line and the data line. Software changes the latch through two write addresses. One address ORs bits into the latch and the other knocks bits out of it, so either line can be moved without a read-modify-write. Each latch bit drives its pad open-drain. A 0 asserts the pull-low enable for that pad. A 1 releases the pad and lets the board's pull-up hold the line high.

The incoming data-line level passes through a reset-to-high synchroniser. A read of the control offset returns the driven clock level together with that synchronised data level, so software can sample acknowledge bits and read data. The register window is 4 KiB and every byte offset in it is decoded in full. A read of any offset other than the control offset returns all ones. A write to any offset other than the set and clear offsets does nothing.

Read responses come from a small machine with three states. RSP_IDLE means no response is due. RSP_CTRL means control-register data is on the bus. RSP_BAD means the all-ones error word is on the bus. On every clock the machine moves from whatever state it is in to RSP_CTRL after a read of offset 0x000, to RSP_BAD after a read of any other offset, and to RSP_IDLE otherwise.

Top module: `twb_bitbang_reg`

## Requirements
- R1: While reset is high and on the first cycle after it, both pull-low enables are 0 (lines released) and rsp_valid is 0. The latch resets to 2'b11.
- R2: A write to offset 0x000 ORs write-data bits [1:0] into the latch. Write-data bits above bit 1 have no effect.
- R3: A write to offset 0x004 clears every latch bit whose matching write-data bit is 1. Bits [1:0] of the write data are used.
- R4: A write to any offset other than 0x000 and 0x004 leaves the latch unchanged.
- R5: The latch drives the pads: scl_pull_low equals the inverse of latch bit 0 and sda_pull_low equals the inverse of latch bit 1. The pads change in the cycle after the write.
- R6: A read of offset 0x000 returns latch bit 0 in bit 0 and the synchronised data-line level in bit 1. Bits [31:2] read as 0.
- R7: A read of any offset other than 0x000 returns 32'hFFFF_FFFF.
- R8: sda_pad_in passes through two flops before it is captured by a read. A read whose request is sampled at clock edge k reports the level sampled at edge k-2.
- R9: rsp_valid is high for exactly the one cycle after each read request and never follows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the 4 KiB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| scl_pull_low | output | 1 | Clock pad pull-low enable (open-drain) |
| sda_pull_low | output | 1 | Data pad pull-low enable (open-drain) |
| sda_pad_in | input | 1 | Level seen on the data pad |

## Verification
A write takes effect on the pull-low enables one cycle after its request. A read answers one cycle after its request, carrying a data-line level that is two edges older than the request edge. The bench drives each request on a falling edge and checks the response and pad outputs on the next falling edge, exactly one rising edge later. It predicts the data bit from its own two-stage history of the pad level, captured as it stood at the falling edge before the request edge. A directed sequence moves the data pad and then reads on three consecutive cycles, expecting old, old, then new, which pins the synchroniser depth.

// File: rtl/twb_pkg.sv
package twb_pkg;
    localparam int unsigned LINE_CNT = 2;
    localparam int unsigned SCL_BIT  = 0;
    localparam int unsigned SDA_BIT  = 1;
    localparam logic [31:0] OFS_SET  = 32'h0000_0000;
    localparam logic [31:0] OFS_CLR  = 32'h0000_0004;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SET,
        ACC_CLR,
        ACC_WR_BAD,
        ACC_RD_CTRL,
        ACC_RD_BAD
    } acc_kind_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_CTRL,
        RSP_BAD
    } rsp_state_t;
endpackage

// File: rtl/twb_decode.sv
module twb_decode
    import twb_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_kind_t         kind
);
    logic hit_set;
    logic hit_clr;

    assign hit_set = (req_addr == OFS_SET[ADDR_W-1:0]);
    assign hit_clr = (req_addr == OFS_CLR[ADDR_W-1:0]);

    always_comb begin
        kind = ACC_NONE;
        if (req_valid) begin
            if (req_write) begin
                if (hit_set)      kind = ACC_SET;
                else if (hit_clr) kind = ACC_CLR;
                else              kind = ACC_WR_BAD;
            end else begin
                kind = hit_set ? ACC_RD_CTRL : ACC_RD_BAD;
            end
        end
    end
endmodule

// File: rtl/twb_latch.sv
module twb_latch
    import twb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  acc_kind_t           kind,
    input  logic [LINE_CNT-1:0] bits,
    output logic [LINE_CNT-1:0] lat_q
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '1;
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            unique case (kind)
                ACC_SET: lat_q <= lat_q | bits;
                ACC_CLR: lat_q <= lat_q & ~bits;
                default: ;
            endcase
        end
    end

    // R2
    set_or_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && kind == ACC_SET) |=> (lat_q == ($past(lat_q) | $past(bits))));

    // R3
    clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && kind == ACC_CLR) |=> (lat_q == ($past(lat_q) & ~$past(bits))));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && kind != ACC_SET && kind != ACC_CLR) |=> $stable(lat_q));
endmodule

// File: rtl/twb_sync.sv
module twb_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st;
    logic              armed;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) st <= RST_VAL;
                else     st <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) st <= {STAGES{RST_VAL}};
                else     st <= {st[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign q = st[STAGES-1];

    // R8
    sync_entry_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (st[0] == $past(d)));

    // R8
    sync_out_age_chk: assert property (@(posedge clk) disable iff (rst)
        armed |=> (q == $past(st[STAGES-1-((STAGES > 1) ? 1 : 0)], 1)) || (STAGES == 1));
endmodule

// File: rtl/twb_resp.sv
module twb_resp
    import twb_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_t         kind,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    rsp_state_t          state_q;
    rsp_state_t          state_d;
    logic [LINE_CNT-1:0] snap_q;
    logic                armed;

    always_comb begin
        unique case (kind)
            ACC_RD_CTRL: state_d = RSP_CTRL;
            ACC_RD_BAD:  state_d = RSP_BAD;
            default:     state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RSP_IDLE;
            snap_q  <= '0;
            armed   <= 1'b0;
        end else begin
            state_q <= state_d;
            armed   <= 1'b1;
            if (kind == ACC_RD_CTRL) begin
                snap_q[SCL_BIT] <= scl_lvl;
                snap_q[SDA_BIT] <= sda_lvl;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_CTRL: begin
                rsp_valid = 1'b1;
                rsp_rdata = DATA_W'(snap_q);
            end
            RSP_BAD: begin
                rsp_valid = 1'b1;
                rsp_rdata = '1;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_rdata = '0;
            end
        endcase
    end

    // R9
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (rsp_valid == $past(kind == ACC_RD_CTRL || kind == ACC_RD_BAD)));

    // R7
    bad_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_RD_BAD) |=> (rsp_rdata == {DATA_W{1'b1}}));

    // R6
    ctrl_word_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_RD_CTRL) |=>
            (rsp_rdata == DATA_W'({$past(sda_lvl), $past(scl_lvl)})));
endmodule

// File: rtl/twb_bitbang_reg.sv
module twb_bitbang_reg
    import twb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    input  logic              sda_pad_in
);
    acc_kind_t           kind;
    logic [LINE_CNT-1:0] lat_q;
    logic                sda_sync;
    logic                unused_hi;

    assign unused_hi = ^req_wdata[DATA_W-1:LINE_CNT];

    twb_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .kind      (kind)
    );

    twb_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .bits  (req_wdata[LINE_CNT-1:0]),
        .lat_q (lat_q)
    );

    twb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_pad_in),
        .q   (sda_sync)
    );

    twb_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .scl_lvl   (lat_q[SCL_BIT]),
        .sda_lvl   (sda_sync),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign scl_pull_low = ~lat_q[SCL_BIT];
    assign sda_pull_low = ~lat_q[SDA_BIT];

    // R1
    idle_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!scl_pull_low && !sda_pull_low && !rsp_valid));
endmodule

// File: tb/test_twb_bitbang_reg.sv
module test_twb_bitbang_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        scl_pull_low;
    logic        sda_pull_low;
    logic        sda_pad_in = 1'b1;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [1:0] m_latch = 2'b11;
    logic h1 = 1'b1;
    logic h2 = 1'b1;

    always #10 clk = ~clk;

    twb_bitbang_reg i_twb_bitbang_reg (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .scl_pull_low (scl_pull_low),
        .sda_pull_low (sda_pull_low),
        .sda_pad_in   (sda_pad_in)
    );

    // two-edge history of the pad level, per R8
    always @(posedge clk) begin
        if (rst) begin
            h1 <= 1'b1;
            h2 <= 1'b1;
        end else begin
            h1 <= sda_pad_in;
            h2 <= h1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] exp_read(input logic [11:0] a, input logic sda_old,
                                             input logic [1:0] lat);
        if (a == 12'h000) return {30'b0, sda_old, lat[0]};
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [1:0] exp_latch(input logic [1:0] lat, input logic [11:0] a,
                                             input logic [31:0] d);
        if (a == 12'h000) return lat | d[1:0];
        if (a == 12'h004) return lat & ~d[1:0];
        return lat;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic do_op(input logic wr, input logic [11:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
        logic [31:0] e_rd;
        string wtag;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        e_rd = exp_read(a, h2, m_latch);
        if (wr) m_latch = exp_latch(m_latch, a, d);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        chk("R9 rsp_valid", {31'b0, rsp_valid}, {31'b0, !wr});
        if (!wr) begin
            if (a == 12'h000) chk("R6/R8 ctrl read", rsp_rdata, e_rd);
            else              chk("R7 bad read", rsp_rdata, e_rd);
        end else begin
            wtag = (a == 12'h000) ? "R2 set" : (a == 12'h004) ? "R3 clear" : "R4 unmapped write";
            chk({wtag, " R5 pads"}, {30'b0, sda_pull_low, scl_pull_low}, {30'b0, ~m_latch});
        end
    endtask

    logic [31:0] rd;

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 reset pads", {30'b0, sda_pull_low, scl_pull_low}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset pads", {30'b0, sda_pull_low, scl_pull_low}, 32'd0);
        chk("R1 after reset rsp_valid", {31'b0, rsp_valid}, 32'd0);

        do_op(1'b0, 12'h000, 32'd0, rd);
        chk("R1 latch reads 11", rd, 32'h3);

        // R3: clear all, both pads pulled low
        do_op(1'b1, 12'h004, 32'hFFFF_FFFF, rd);
        chk("R5 both pulled", {30'b0, sda_pull_low, scl_pull_low}, 32'h3);
        // R2: upper bits ignored
        do_op(1'b1, 12'h000, 32'hFFFF_FFFC, rd);
        chk("R2 high bits ignored", {30'b0, sda_pull_low, scl_pull_low}, 32'h3);
        do_op(1'b1, 12'h000, 32'h1, rd);
        chk("R5 scl released only", {30'b0, sda_pull_low, scl_pull_low}, 32'h2);
        // R4: unmapped writes
        do_op(1'b1, 12'h008, 32'h3, rd);
        do_op(1'b1, 12'hFFC, 32'h3, rd);
        chk("R4 latch kept", {30'b0, sda_pull_low, scl_pull_low}, 32'h2);
        // R7: unmapped reads
        do_op(1'b0, 12'hFFC, 32'd0, rd);
        do_op(1'b0, 12'h004, 32'd0, rd);

        // R8: directed latency of the data-line synchroniser
        repeat (4) @(negedge clk);
        sda_pad_in = 1'b0;
        do_op(1'b0, 12'h000, 32'd0, rd);
        chk("R8 read 1 old level", {31'b0, rd[1]}, 32'd1);
        do_op(1'b0, 12'h000, 32'd0, rd);
        chk("R8 read 2 old level", {31'b0, rd[1]}, 32'd1);
        do_op(1'b0, 12'h000, 32'd0, rd);
        chk("R8 read 3 new level", {31'b0, rd[1]}, 32'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic        wr;
            case ($urandom % 6)
                0: a = 12'h000;
                1: a = 12'h004;
                2: a = 12'h008;
                3: a = 12'hFFC;
                4: a = 12'h001;
                default: a = 12'($urandom);
            endcase
            if ($urandom % 3 == 0) a = 12'h000;
            d  = $urandom;
            wr = ($urandom % 2) == 1;
            if ($urandom % 4 == 0) sda_pad_in = ~sda_pad_in;
            do_op(wr, a, d, rd);
            if ($urandom % 5 == 0) @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule